// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Table

This block keeps a table of per-vector message targets and a pending-bit array for `NUM_VEC` interrupt vectors. Software reaches both through a 32-bit register port. Each table entry gives one vector a 64-bit message address, a 32-bit message payload and a control word. Bit 0 of the control word masks that vector. The pending bits can only be read.

The device raises per-vector request levels. On each rising level the block decides what to do. If the vector can deliver, the block issues one message write. If the vector is masked, either by the global function mask, by a low global enable or by its own mask bit, the block records the event as a pending bit. Pending events are sent later, when one of these happens:
- software rewrites any dword of that vector's entry and the vector is no longer masked;
- the function as a whole becomes unmasked and enabled.

Messages leave on a valid/ready channel that holds one message at a time. Requests that arrive while the channel is busy are latched and handled in order of vector index.

Top module: `msix_vec_unit`

## Requirements
- R1: Entry i occupies bytes 16*i to 16*i+15 of the region. Its four dwords are, by byte offset within the entry: 0 message address low, 4 message address high, 8 message data, 12 control. A legal read returns the last value written to that dword.
- R2: Bit 0 of an entry's control dword masks that vector. After reset every control dword reads 1 and every other table dword reads 0.
- R3: The pending array starts at byte offset `NUM_VEC*16`. Vector i is bit (i mod 32) of the dword at `NUM_VEC*16 + 4*(i/32)`, which is the same as bit (i mod 8) of byte i/8. Bits with no vector read 0, and all pending bits are 0 after reset.
- R4: The region spans the table plus the pending bytes, rounded up to a multiple of 4096 bytes. A legal read inside the region but past the pending dwords returns 0. A read at or beyond the region end returns 32'hFFFFFFFF.
- R5: `mmio_size` encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. An access with a size other than 2, or with address bits [1:0] not zero, responds with `mmio_rsp_err` = 1 and data 0, and changes nothing.
- R6: A write at or above the pending-array offset is ignored, with no error. The pending bits, the table and the messages are all unaffected.
- R7: Only a 0-to-1 change of `irq_req[i]` acts. A level held high or held low causes no further message and no pending change.
- R8: A rising request on a vector that is masked sets that vector's pending bit and sends nothing. Masked here means `func_mask` = 1, `msix_enable` = 0, or the vector's mask bit = 1.
- R9: A rising request on an unmasked vector clears its pending bit and sends one message. The address is {address high, address low with bits [1:0] forced to 0}. The data is the entry's data dword.
- R10: After a legal table write, the vector holding that dword is re-checked. If it is pending and unmasked, its message is sent and its pending bit is cleared.
- R11: When the function goes from masked or disabled to unmasked and enabled, every pending unmasked vector is sent, lowest index first.
- R12: `msg_addr` and `msg_data` stay stable while `msg_valid` is high and `msg_ready` is low. Requests arriving while a message waits are kept and served afterwards, so none is lost.
- R13: Every register-port request gets `mmio_rsp_valid` exactly one cycle later. A write takes effect at the same clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mmio_valid | input | 1 | Register access request |
| mmio_write | input | 1 | 1 = write, 0 = read |
| mmio_addr | input | ADDR_W | Byte offset within the region |
| mmio_size | input | 2 | Access size code (see R5) |
| mmio_wdata | input | 32 | Write data |
| mmio_rsp_valid | output | 1 | Response strobe, one cycle after request |
| mmio_rsp_err | output | 1 | Illegal size or alignment |
| mmio_rdata | output | 32 | Read data |
| irq_req | input | NUM_VEC | Per-vector request levels |
| func_mask | input | 1 | Global function mask |
| msix_enable | input | 1 | Global enable |
| msg_valid | output | 1 | Message write is offered |
| msg_ready | input | 1 | Message write is accepted |
| msg_addr | output | 64 | Message address, bits [1:0] zero |
| msg_data | output | 32 | Message payload |

## Verification
Two functions can fall in the same cycle: a table write that re-checks a vector, and a request edge or a global unmask that schedules other vectors. A third overlap is a request edge arriving while a message waits on the output. The bench provokes these cases in three ways:
- it unmasks a pending vector by a table write;
- it releases the function mask with two vectors pending;
- it holds `msg_ready` low while raising a second request.

A scoreboard fed by the stimulus tasks judges the outcome. It expects exactly the listed messages, in vector order. It flags any extra message and any message left unsent. Register-port reads of the pending array confirm which events were latched and which were sent.

// File: rtl/msix_pkg.sv
// Package: shared entry layout and constants for the vector table.
// Assumes little-endian dword order within an entry as listed below.
package msix_pkg;
    localparam int ENTRY_BYTES = 16;
    localparam int PAGE_BYTES  = 4096;
    localparam logic [1:0] SIZE_DWORD = 2'd2;

    // One table entry; field order matches dword order 3..0
    typedef struct packed {
        logic [31:0] ctrl;
        logic [31:0] data;
        logic [31:0] addr_hi;
        logic [31:0] addr_lo;
    } msix_entry_t;
endpackage

// File: rtl/msix_table.sv
// Module: msix_table
// Holds the vector table registers and serves the 32-bit register port,
// including pending-array reads. Flags which vector a legal table write
// touched so the engine can re-check it.
// Assumes ADDR_W is wide enough to address beyond the region end.
module msix_table #(
    parameter int NUM_VEC = 8,
    parameter int ADDR_W  = 16
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   req_valid,
    input  logic                                   req_write,
    input  logic [ADDR_W-1:0]                      req_addr,
    input  logic [1:0]                             req_size,
    input  logic [31:0]                            req_wdata,
    input  logic [NUM_VEC-1:0]                     pend,
    output logic                                   rsp_valid,
    output logic                                   rsp_err,
    output logic [31:0]                            rsp_rdata,
    output msix_pkg::msix_entry_t [NUM_VEC-1:0]    ent,
    output logic [NUM_VEC-1:0]                     touch
);
    import msix_pkg::*;

    localparam int PBA_OFF   = NUM_VEC * ENTRY_BYTES;
    localparam int PBA_BYTES = (NUM_VEC + 7) / 8;
    localparam int PBA_DW    = (NUM_VEC + 31) / 32;
    localparam int REGION    = ((PBA_OFF + PBA_BYTES + PAGE_BYTES - 1) / PAGE_BYTES) * PAGE_BYTES;

    logic [31:0]          a32;
    logic                 legal;
    logic                 in_tab;
    logic                 wr_ok;
    logic [ADDR_W-5:0]    ent_idx;
    logic [1:0]           dw_sel;
    logic [31:0]          pidx;
    logic [PBA_DW*32-1:0] pend_pad;
    logic [31:0]          rd_word;

    assign a32     = 32'(req_addr);
    assign legal   = (req_size == SIZE_DWORD) && (req_addr[1:0] == 2'b00);
    assign in_tab  = a32 < 32'(PBA_OFF);
    assign wr_ok   = req_valid && req_write && legal && in_tab;
    assign ent_idx = req_addr[ADDR_W-1:4];
    assign dw_sel  = req_addr[3:2];
    assign pidx    = (a32 - 32'(PBA_OFF)) >> 2;

    // Per-entry write decode
    for (genvar i = 0; i < NUM_VEC; i++) begin : g_sel
        assign touch[i] = wr_ok && (ent_idx == (ADDR_W-4)'(i));
    end

    // Pad pending bits out to whole dwords
    always_comb begin
        pend_pad = '0;
        pend_pad[NUM_VEC-1:0] = pend;
    end

    // Read multiplexer over table, pending dwords, gap and out-of-region
    always_comb begin
        rd_word = '0;
        if (a32 >= 32'(REGION)) begin
            rd_word = '1;
        end else if (in_tab) begin
            for (int i = 0; i < NUM_VEC; i++) begin
                if (ent_idx == (ADDR_W-4)'(i)) begin
                    case (dw_sel)
                        2'd0:    rd_word = ent[i].addr_lo;
                        2'd1:    rd_word = ent[i].addr_hi;
                        2'd2:    rd_word = ent[i].data;
                        default: rd_word = ent[i].ctrl;
                    endcase
                end
            end
        end else begin
            for (int k = 0; k < PBA_DW; k++) begin
                if (pidx == 32'(k)) rd_word = pend_pad[k*32 +: 32];
            end
        end
    end

    // Table storage: reset with every vector masked, written on legal table hits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_VEC; i++) begin
                ent[i]         <= '0;
                ent[i].ctrl[0] <= 1'b1;
            end
        end else begin
            for (int i = 0; i < NUM_VEC; i++) begin
                if (touch[i]) begin
                    case (dw_sel)
                        2'd0:    ent[i].addr_lo <= req_wdata;
                        2'd1:    ent[i].addr_hi <= req_wdata;
                        2'd2:    ent[i].data    <= req_wdata;
                        default: ent[i].ctrl    <= req_wdata;
                    endcase
                end
            end
        end
    end

    // Response register: one cycle after every request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && !legal;
            rsp_rdata <= (req_valid && !req_write && legal) ? rd_word : '0;
        end
    end

    a_r13_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r5_bad_size_err: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_size != SIZE_DWORD)) |=> (rsp_err && rsp_rdata == 32'd0));
    a_r6_pba_readonly: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && (a32 >= 32'(PBA_OFF))) |=> $stable(ent));
endmodule

// File: rtl/msix_engine.sv
// Module: msix_engine
// Detects request edges and latches them per vector, merges table-write and
// global-unmask re-checks, and serves one vector per cycle (lowest index
// first) while the message output is idle. Owns the pending bits.
// Assumes the entry inputs reflect the table registers of this cycle.
module msix_engine #(
    parameter int NUM_VEC = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_VEC-1:0]                  irq_req,
    input  logic                                func_mask,
    input  logic                                enable,
    input  msix_pkg::msix_entry_t [NUM_VEC-1:0] ent,
    input  logic [NUM_VEC-1:0]                  touch,
    output logic [NUM_VEC-1:0]                  pend,
    output logic                                msg_valid,
    input  logic                                msg_ready,
    output logic [63:0]                         msg_addr,
    output logic [31:0]                         msg_data
);
    localparam int VW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

    logic [NUM_VEC-1:0] irq_q;
    logic [NUM_VEC-1:0] hold;
    logic [NUM_VEC-1:0] recheck;
    logic [NUM_VEC-1:0] vec_masked;
    logic [NUM_VEC-1:0] work;
    logic [NUM_VEC-1:0] clr;
    logic [NUM_VEC-1:0] rescan_set;
    logic               active;
    logic               active_q;
    logic [VW-1:0]      sel;
    logic               go;
    logic               sel_masked;
    logic               send;
    logic               latch_pend;
    logic               unused_bits;

    assign active = enable && !func_mask;

    // Per-vector effective mask
    for (genvar i = 0; i < NUM_VEC; i++) begin : g_mask
        assign vec_masked[i] = !active || ent[i].ctrl[0];
    end

    assign work       = hold | recheck;
    assign rescan_set = (active && !active_q) ? '1 : '0;

    // Lowest-index pick among vectors awaiting a decision
    always_comb begin
        sel = '0;
        for (int i = NUM_VEC - 1; i >= 0; i--) begin
            if (work[i]) sel = VW'(i);
        end
    end

    assign go         = !msg_valid && (|work);
    assign sel_masked = vec_masked[sel];
    assign send       = go && !sel_masked && (hold[sel] || pend[sel]);
    assign latch_pend = go && hold[sel] && sel_masked;

    // One-hot clear of the served vector's latches
    always_comb begin
        clr = '0;
        if (go) clr[sel] = 1'b1;
    end

    // Edge history, request latches and re-check latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q    <= '0;
            hold     <= '0;
            recheck  <= '0;
            active_q <= 1'b0;
        end else begin
            irq_q    <= irq_req;
            hold     <= (hold & ~clr) | (irq_req & ~irq_q);
            recheck  <= (recheck & ~clr) | touch | rescan_set;
            active_q <= active;
        end
    end

    // Pending bits: set on masked request, cleared on send
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else if (latch_pend) begin
            pend[sel] <= 1'b1;
        end else if (send) begin
            pend[sel] <= 1'b0;
        end
    end

    // Single-entry message output with valid/ready handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid <= 1'b0;
            msg_addr  <= '0;
            msg_data  <= '0;
        end else if (send) begin
            msg_valid <= 1'b1;
            msg_addr  <= {ent[sel].addr_hi, ent[sel].addr_lo[31:2], 2'b00};
            msg_data  <= ent[sel].data;
        end else if (msg_valid && msg_ready) begin
            msg_valid <= 1'b0;
        end
    end

    // Control and address bits with no function here
    always_comb begin
        unused_bits = 1'b0;
        for (int i = 0; i < NUM_VEC; i++) begin
            unused_bits = unused_bits ^ (^ent[i].ctrl[31:1]) ^ (^ent[i].addr_lo[1:0]);
        end
    end

    a_r12_msg_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));
    a_r9_send_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> !$past(sel_masked));
    a_r9_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_addr[1:0] == 2'b00));
    for (genvar i = 0; i < NUM_VEC; i++) begin : g_chk
        a_r8_pend_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend[i]) |-> $past(vec_masked[i]));
    end
endmodule

// File: rtl/msix_vec_unit.sv
// Module: msix_vec_unit (top)
// Vector table, pending array and message issue for NUM_VEC vectors.
// Assumes requests are level signals; edges of one vector closer together
// than its service latency merge into one event.
module msix_vec_unit #(
    parameter int NUM_VEC = 8,
    parameter int ADDR_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mmio_valid,
    input  logic               mmio_write,
    input  logic [ADDR_W-1:0]  mmio_addr,
    input  logic [1:0]         mmio_size,
    input  logic [31:0]        mmio_wdata,
    output logic               mmio_rsp_valid,
    output logic               mmio_rsp_err,
    output logic [31:0]        mmio_rdata,
    input  logic [NUM_VEC-1:0] irq_req,
    input  logic               func_mask,
    input  logic               msix_enable,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [63:0]        msg_addr,
    output logic [31:0]        msg_data
);
    msix_pkg::msix_entry_t [NUM_VEC-1:0] ent;
    logic [NUM_VEC-1:0]                  touch;
    logic [NUM_VEC-1:0]                  pend;

    msix_table #(.NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (mmio_valid),
        .req_write (mmio_write),
        .req_addr  (mmio_addr),
        .req_size  (mmio_size),
        .req_wdata (mmio_wdata),
        .pend      (pend),
        .rsp_valid (mmio_rsp_valid),
        .rsp_err   (mmio_rsp_err),
        .rsp_rdata (mmio_rdata),
        .ent       (ent),
        .touch     (touch)
    );

    msix_engine #(.NUM_VEC(NUM_VEC)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_req   (irq_req),
        .func_mask (func_mask),
        .enable    (msix_enable),
        .ent       (ent),
        .touch     (touch),
        .pend      (pend),
        .msg_valid (msg_valid),
        .msg_ready (msg_ready),
        .msg_addr  (msg_addr),
        .msg_data  (msg_data)
    );
endmodule

// File: tb/tb_msix_vec_unit.sv
`timescale 1ns/1ps
module tb_msix_vec_unit;
    localparam int NV = 8;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mmio_valid = 1'b0;
    logic          mmio_write = 1'b0;
    logic [AW-1:0] mmio_addr = '0;
    logic [1:0]    mmio_size = 2'd2;
    logic [31:0]   mmio_wdata = '0;
    logic          mmio_rsp_valid;
    logic          mmio_rsp_err;
    logic [31:0]   mmio_rdata;
    logic [NV-1:0] irq_req = '0;
    logic          func_mask = 1'b0;
    logic          msix_enable = 1'b1;
    logic          msg_valid;
    logic          msg_ready = 1'b1;
    logic [63:0]   msg_addr;
    logic [31:0]   msg_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [95:0] exp_q [$];
    logic [31:0] m_lo [NV];
    logic [31:0] m_hi [NV];
    logic [31:0] m_dt [NV];

    always #2.5 clk = ~clk;

    msix_vec_unit #(.NUM_VEC(NV), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .mmio_valid(mmio_valid), .mmio_write(mmio_write),
        .mmio_addr(mmio_addr), .mmio_size(mmio_size), .mmio_wdata(mmio_wdata),
        .mmio_rsp_valid(mmio_rsp_valid), .mmio_rsp_err(mmio_rsp_err), .mmio_rdata(mmio_rdata),
        .irq_req(irq_req), .func_mask(func_mask), .msix_enable(msix_enable),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
    );

    task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic mmio(input bit wr, input logic [AW-1:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd, output logic er);
        @(negedge clk);
        mmio_valid = 1'b1; mmio_write = wr; mmio_addr = a; mmio_size = sz; mmio_wdata = wd;
        @(negedge clk);
        mmio_valid = 1'b0;
        check("R13 response strobe", 96'(mmio_rsp_valid), 96'd1);
        rd = mmio_rdata;
        er = mmio_rsp_err;
    endtask

    task automatic wr32(input logic [AW-1:0] a, input logic [31:0] d);
        logic [31:0] rd; logic er;
        mmio(1'b1, a, 2'd2, d, rd, er);
        if (a < AW'(NV*16)) begin
            case (a[3:2])
                2'd0: m_lo[a[AW-1:4]] = d;
                2'd1: m_hi[a[AW-1:4]] = d;
                2'd2: m_dt[a[AW-1:4]] = d;
                default: ;
            endcase
        end
    endtask

    task automatic rd32(input logic [AW-1:0] a, output logic [31:0] d);
        logic er;
        mmio(1'b0, a, 2'd2, 32'd0, d, er);
    endtask

    task automatic expect_msg(input int v);
        exp_q.push_back({m_hi[v], m_lo[v] & 32'hFFFF_FFFC, m_dt[v]});
    endtask

    task automatic pulse(input int v);
        @(negedge clk); irq_req[v] = 1'b1;
        repeat (3) @(negedge clk);
        irq_req[v] = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic drain(input string req);
        repeat (20) @(negedge clk);
        check(req, 96'(exp_q.size()), 96'd0);
    endtask

    // Monitor: compare each accepted message against the scoreboard
    initial begin
        forever begin
            @(negedge clk); #1;
            if (msg_valid && msg_ready) begin
                if (exp_q.size() == 0) begin
                    check("R7 unexpected message", {msg_addr, msg_data}, 96'd0);
                end else begin
                    check("R9 message content", {msg_addr, msg_data}, exp_q.pop_front());
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL R12 watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic er;
        logic [63:0] held_a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        check("R12 reset msg_valid", 96'(msg_valid), 96'd0);
        rd32(16'h000C, d); check("R2 reset control mask", 96'(d), 96'd1);
        rd32(16'h0004, d); check("R2 reset address high", 96'(d), 96'd0);
        rd32(16'h0080, d); check("R3 reset pending", 96'(d), 96'd0);

        // Program every entry
        for (int i = 0; i < NV; i++) begin
            wr32(AW'(i*16),      32'hFEE0_0003 + 32'(i << 4));
            wr32(AW'(i*16 + 4),  32'h0000_0100 + 32'(i));
            wr32(AW'(i*16 + 8),  32'h0000_4000 + 32'(i));
            wr32(AW'(i*16 + 12), 32'h0);
        end
        rd32(16'h0020, d); check("R1 entry2 address low", 96'(d), 96'hFEE0_0023);
        rd32(16'h0024, d); check("R1 entry2 address high", 96'(d), 96'h102);
        rd32(16'h0028, d); check("R1 entry2 data", 96'(d), 96'h4002);
        drain("R10 no message from clean rewrite");

        // Unmasked request sends; level held high sends once
        expect_msg(1);
        @(negedge clk); irq_req[1] = 1'b1;
        repeat (30) @(negedge clk);
        check("R7 held level sends once", 96'(exp_q.size()), 96'd0);
        irq_req[1] = 1'b0;
        drain("R9 unmasked send");
        rd32(16'h0080, d); check("R9 pending clear after send", 96'(d), 96'd0);

        // Vector mask latches pending, table write re-check sends it
        wr32(16'h003C, 32'h1);
        pulse(3);
        drain("R8 masked vector sends nothing");
        rd32(16'h0080, d); check("R8 R3 pending bit 3", 96'(d), 96'h08);
        expect_msg(3);
        wr32(16'h003C, 32'h0);
        drain("R10 re-check sends pending");
        rd32(16'h0080, d); check("R10 pending cleared", 96'(d), 96'h0);

        // Function mask: two pending, released lowest first
        func_mask = 1'b1;
        pulse(5);
        pulse(0);
        drain("R8 function mask blocks");
        rd32(16'h0080, d); check("R8 pending bits 0 and 5", 96'(d), 96'h21);
        expect_msg(0);
        expect_msg(5);
        @(negedge clk); func_mask = 1'b0;
        drain("R11 release in index order");
        rd32(16'h0080, d); check("R11 pending cleared", 96'(d), 96'h0);

        // Pending array is read-only
        wr32(16'h006C, 32'h1);
        pulse(6);
        wr32(16'h0080, 32'h0);
        wr32(16'h0080, 32'hFF);
        rd32(16'h0080, d); check("R6 pending write ignored", 96'(d), 96'h40);
        drain("R6 no message from pending write");
        expect_msg(6);
        wr32(16'h006C, 32'h0);
        drain("R10 unmask vector 6");

        // Illegal sizes and alignment
        mmio(1'b1, 16'h0008, 2'd1, 32'hDEAD_BEEF, d, er);
        check("R5 short write error", 96'(er), 96'd1);
        rd32(16'h0008, d); check("R5 short write no effect", 96'(d), 96'h4000);
        mmio(1'b0, 16'h0009, 2'd2, 32'd0, d, er);
        check("R5 misaligned read error and data", {64'(er), d}, {64'd1, 32'd0});
        mmio(1'b0, 16'h0000, 2'd3, 32'd0, d, er);
        check("R5 wide read error", 96'(er), 96'd1);

        // Region boundaries
        rd32(16'h0084, d); check("R4 gap after pending", 96'(d), 96'd0);
        rd32(16'h0FFC, d); check("R4 last dword in region", 96'(d), 96'd0);
        rd32(16'h1000, d); check("R4 region end", 96'(d), 96'hFFFF_FFFF);
        rd32(16'h2004, d); check("R4 beyond region", 96'(d), 96'hFFFF_FFFF);

        // Back-pressure: message held stable, later request kept
        @(negedge clk); msg_ready = 1'b0;
        expect_msg(2);
        expect_msg(4);
        pulse(2);
        held_a = msg_addr;
        pulse(4);
        repeat (5) @(negedge clk);
        check("R12 held valid and address", {31'd0, msg_valid, held_a}, {31'd0, 1'b1, 64'h0000_0102_FEE0_0020});
        check("R12 address stable", 96'(msg_addr), 96'(held_a));
        @(negedge clk); msg_ready = 1'b1;
        drain("R12 both delivered in order");

        // Global enable low behaves as masked
        @(negedge clk); msix_enable = 1'b0;
        pulse(7);
        drain("R8 disabled sends nothing");
        rd32(16'h0080, d); check("R8 pending bit 7", 96'(d), 96'h80);
        expect_msg(7);
        @(negedge clk); msix_enable = 1'b1;
        drain("R11 enable releases pending");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule